// File: doc/BRIEF.md
# Serial PRBS Receiver with Bit-Error Accounting

This block takes a serial test stream that a matching transmitter produced from a programmable linear feedback polynomial. It locks onto that stream without a seed or a start marker, and measures the stream quality. The local predictor is filled directly from the received bits. It then has to predict a run of consecutive bits correctly before the block reports lock. Once locked, the predictor runs on its own output, so a corrupted input bit shows up as exactly one error and does not spread.

A sliding record of the last 64 locked bits tracks how dense the errors are. Too many errors in that record drop lock, raise a loss flag and start a new search. Two saturating accumulators count enabled clocks and locked bit errors. Software flips a single level input to copy both accumulators into the output registers, and the accumulators clear in the same clock. A clock enable stalls the whole receiver, so a gapped or time-slotted stream can be measured.

Top module: `prbs_rx`

## Requirements
- R1: After reset, sync_o and los_o are 0 and both latched counts are 0.
- R2: A search shifts len_i received bits into the predictor. It then needs 50 consecutive correct predictions, so sync_o rises right after the len_i+50th enabled clock of an error-free search.
- R3: Bit i of taps_i selects the bit received i+1 enabled clocks earlier. The predicted bit is the XOR of the selected bits, so the feedback x^n + x^k + 1 uses taps bits n-1 and k-1.
- R4: A wrong prediction during the 50-bit check restarts the search with a new len_i-bit load, so lock comes len_i+50 enabled clocks after the errored bit.
- R5: While locked, the predictor advances on its own predicted bit, and each received bit that differs from the prediction adds one to the error accumulator. Bits received while not locked never add to it.
- R6: While locked, an errored bit that brings the count of errored bits among the last 64 locked bits to 6 drops sync_o and sets los_o on that clock, and a search restarts. Five errors inside any 64-bit span keep lock.
- R7: With en_i low, the predictor, the search and lock state, and both accumulators hold their values.
- R8: The bit accumulator adds one on every clock with en_i high, whatever the lock state.
- R9: On a clock where lc_i differs from its value on the previous clock, bit_cnt_o and err_cnt_o take the accumulator values from before that clock's increment. On that same clock each accumulator restarts at that clock's own increment (0 or 1).
- R10: Both accumulators saturate at all ones instead of wrapping.
- R11: los_o stays set until the next lc_i change. If a loss and an lc_i change fall on the same clock, los_o is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; the bit on data_i is taken only when high |
| data_i | input | 1 | Received serial bit |
| taps_i | input | MAX_LEN | Feedback tap mask (R3) |
| len_i | input | clog2(MAX_LEN+1) | Polynomial degree, number of bits loaded per search |
| lc_i | input | 1 | Latch-and-clear control; any change acts |
| sync_o | output | 1 | Pattern lock |
| los_o | output | 1 | Sticky loss-of-lock flag |
| bit_cnt_o | output | CNT_W | Latched enabled-clock count |
| err_cnt_o | output | CNT_W | Latched locked error count |

## Verification
The assertions assume that taps_i and len_i stay constant between resets and that no set tap lies at or above len_i. They also assume lc_i changes only while reset is released. The stimulus uses a fresh reset for every polynomial it sweeps, uses only taps that fit below the degree, and changes lc_i only through the stepping task, so every change is sampled on a clock edge. The accumulators are shrunk to 10 bits so that saturation can be reached within a short run.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;
  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCK   = 2'd2
  } rx_state_e;
endpackage

// File: rtl/prbs_rx_lfsr.sv
module prbs_rx_lfsr #(
  parameter int MAX_LEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               track_i,   // 1: shift received bit, 0: free-run
  input  logic               rx_bit_i,
  input  logic [MAX_LEN-1:0] taps_i,
  output logic               pred_o
);
  logic [MAX_LEN-1:0] hist_q;

  assign pred_o = ^(hist_q & taps_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hist_q <= '0;
    else if (en_i) hist_q <= {hist_q[MAX_LEN-2:0], track_i ? rx_bit_i : pred_o};
  end
endmodule

// File: rtl/prbs_rx_sync.sv
module prbs_rx_sync
  import prbs_rx_pkg::*;
#(
  parameter int MAX_LEN    = 32,
  parameter int WIN        = 64,
  parameter int ERR_LIMIT  = 6,
  parameter int MATCH_NEED = 50,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int MW = $clog2(MATCH_NEED + 1),
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          err_i,
  input  logic [LW-1:0] len_i,
  input  logic          clr_los_i,
  output logic          lock_o,
  output logic          track_o,
  output logic          los_o
);
  rx_state_e      st_q;
  logic [LW-1:0]  ld_cnt_q;
  logic [MW-1:0]  match_q;
  logic [WIN-1:0] win_q;
  logic [CW-1:0]  win_cnt_q;
  logic [CW-1:0]  win_cnt_n;
  logic           loss;

  assign win_cnt_n = win_cnt_q + CW'(err_i) - CW'(win_q[WIN-1]);
  assign loss      = en_i && (st_q == ST_LOCK) && (win_cnt_n >= CW'(ERR_LIMIT));
  assign lock_o    = (st_q == ST_LOCK);
  assign track_o   = (st_q != ST_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_LOAD;
      ld_cnt_q  <= '0;
      match_q   <= '0;
      win_q     <= '0;
      win_cnt_q <= '0;
    end else if (en_i) begin
      unique case (st_q)
        ST_LOAD: begin
          if ({1'b0, ld_cnt_q} + 1'b1 >= {1'b0, len_i}) begin
            st_q    <= ST_VERIFY;
            match_q <= '0;
          end
          ld_cnt_q <= ld_cnt_q + 1'b1;
        end
        ST_VERIFY: begin
          if (err_i) begin
            st_q     <= ST_LOAD;
            ld_cnt_q <= '0;
          end else if (match_q == MW'(MATCH_NEED - 1)) begin
            st_q      <= ST_LOCK;
            win_q     <= '0;
            win_cnt_q <= '0;
          end else begin
            match_q <= match_q + 1'b1;
          end
        end
        default: begin
          if (loss) begin
            st_q     <= ST_LOAD;
            ld_cnt_q <= '0;
          end
          win_q     <= {win_q[WIN-2:0], err_i};
          win_cnt_q <= win_cnt_n;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        los_o <= 1'b0;
    else if (loss)      los_o <= 1'b1;
    else if (clr_los_i) los_o <= 1'b0;
  end
endmodule

// File: rtl/prbs_rx_acc.sv
module prbs_rx_acc #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         latch_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_o <= '0;
    end else if (latch_i) begin
      cnt_o <= acc_q;
      acc_q <= W'(inc_i);
    end else if (inc_i && !(&acc_q)) begin
      acc_q <= acc_q + 1'b1;
    end
  end
endmodule

// File: rtl/prbs_rx.sv
module prbs_rx #(
  parameter int MAX_LEN    = 32,
  parameter int CNT_W      = 48,
  parameter int WIN        = 64,
  parameter int ERR_LIMIT  = 6,
  parameter int MATCH_NEED = 50,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               data_i,
  input  logic [MAX_LEN-1:0] taps_i,
  input  logic [LW-1:0]      len_i,
  input  logic               lc_i,
  output logic               sync_o,
  output logic               los_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [CNT_W-1:0]   err_cnt_o
);
  logic pred, err_bit, track, lock, lc_q, lc_tog;
  logic [1:0] inc;
  logic [1:0][CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lc_q <= 1'b0;
    else         lc_q <= lc_i;
  end
  assign lc_tog  = lc_i ^ lc_q;
  assign err_bit = data_i ^ pred;

  prbs_rx_lfsr #(.MAX_LEN(MAX_LEN)) u_lfsr (
    .clk_i, .rst_ni, .en_i,
    .track_i(track), .rx_bit_i(data_i), .taps_i, .pred_o(pred)
  );

  prbs_rx_sync #(
    .MAX_LEN(MAX_LEN), .WIN(WIN), .ERR_LIMIT(ERR_LIMIT), .MATCH_NEED(MATCH_NEED)
  ) u_sync (
    .clk_i, .rst_ni, .en_i, .err_i(err_bit), .len_i, .clr_los_i(lc_tog),
    .lock_o(lock), .track_o(track), .los_o
  );

  assign inc[0] = en_i;
  assign inc[1] = en_i & lock & err_bit;

  for (genvar g = 0; g < 2; g++) begin : g_acc
    prbs_rx_acc #(.W(CNT_W)) u_acc (
      .clk_i, .rst_ni, .inc_i(inc[g]), .latch_i(lc_tog), .cnt_o(cnt[g])
    );
  end

  assign sync_o    = lock;
  assign bit_cnt_o = cnt[0];
  assign err_cnt_o = cnt[1];
endmodule

// File: rtl/prbs_rx_chk.sv
module prbs_rx_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             lc_i,
  input logic             sync_o,
  input logic             los_o,
  input logic [CNT_W-1:0] bit_cnt_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  logic lc_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lc_seen <= 1'b0;
    else         lc_seen <= lc_i;
  end

  // R9
  latch_only_on_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lc_i == lc_seen) |=> ($stable(bit_cnt_o) && $stable(err_cnt_o)));

  // R7
  stall_holds_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sync_o));

  // R2
  lock_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(en_i));

  // R6
  loss_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> los_o);

  // R11
  flag_only_on_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_o) |-> $fell(sync_o));
endmodule

bind prbs_rx prbs_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .en_i, .lc_i, .sync_o, .los_o, .bit_cnt_o, .err_cnt_o
);

// File: tb/prbs_rx_test.sv
module prbs_rx_test;
  localparam int MAX_LEN = 32;
  localparam int CNT_W   = 10;
  localparam int LW      = $clog2(MAX_LEN + 1);
  localparam longint SAT = (64'd1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, din = 1'b0, lc = 1'b0;
  logic [MAX_LEN-1:0] taps = '0;
  logic [LW-1:0] len = '0;
  logic sync, los;
  logic [CNT_W-1:0] bit_cnt, err_cnt;

  int vectors = 0, miscompares = 0;
  longint acc_bit = 0;
  logic [MAX_LEN-1:0] hist;

  always #10 clk = ~clk;

  prbs_rx #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .data_i(din), .taps_i(taps),
    .len_i(len), .lc_i(lc), .sync_o(sync), .los_o(los),
    .bit_cnt_o(bit_cnt), .err_cnt_o(err_cnt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic gen_peek();
    return ^(hist & taps);
  endfunction

  // drive one clock; flip corrupts the bit; sample at posedge+5
  task automatic step(input logic flip, input logic enable, input logic tog);
    logic b;
    @(negedge clk);
    b   = gen_peek();
    din = enable ? (b ^ flip) : ~b;
    en  = enable;
    if (tog) lc = ~lc;
    @(posedge clk);
    if (enable) hist = {hist[MAX_LEN-2:0], b};
    if (tog) acc_bit = enable ? 1 : 0;
    else if (enable && acc_bit < SAT) acc_bit++;
    #5;
  endtask

  task automatic do_reset(input logic [MAX_LEN-1:0] t, input int n);
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; lc = 1'b0;
    taps = t; len = LW'(n);
    hist = MAX_LEN'(32'h5a3c_e1b7) | 1;
    acc_bit = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_poly(input logic [MAX_LEN-1:0] t, input int n);
    longint lat;
    do_reset(t, n);
    #1;
    chk("R1 sync", sync, 0);
    chk("R1 los", los, 0);
    chk("R1 bits", bit_cnt, 0);
    chk("R1 errs", err_cnt, 0);
    for (int k = 1; k <= n + 50; k++) begin
      step(0, 1, 0);
      if (k == n + 49) chk("R2 early", sync, 0);
      if (k == n + 50) chk("R2 R3 lock", sync, 1);
    end
    lat = acc_bit;
    step(0, 1, 1);
    chk("R8 R9 bits", bit_cnt, lat);
    chk("R5 no search errs", err_cnt, 0);
    // stall with garbage data
    for (int k = 0; k < 5; k++) step(0, 0, 0);
    chk("R7 lock held", sync, 1);
    for (int k = 0; k < 20; k++) step(0, 1, 0);
    lat = acc_bit;
    step(0, 1, 1);
    chk("R7 R8 bits", bit_cnt, lat);
    chk("R7 no errs after stall", err_cnt, 0);
    // five errors, sixth 64 bits after the first: lock kept
    for (int k = 0; k < 5; k++) step(1, 1, 0);
    for (int k = 5; k < 64; k++) step(0, 1, 0);
    step(1, 1, 0);
    chk("R6 five in window", sync, 1);
    for (int k = 0; k < 70; k++) step(0, 1, 0);
    // six within 64: loss on the sixth
    for (int k = 0; k < 5; k++) step(1, 1, 0);
    for (int k = 5; k < 63; k++) step(0, 1, 0);
    chk("R6 before sixth", sync, 1);
    step(1, 1, 0);
    chk("R6 loss", sync, 0);
    chk("R6 flag", los, 1);
    // search again with one wrong bit inside the check run
    for (int k = 0; k < n + 9; k++) step(0, 1, 0);
    step(1, 1, 0);
    for (int k = 1; k <= n + 50; k++) begin
      step(0, 1, 0);
      if (k == n + 49) chk("R4 restart early", sync, 0);
      if (k == n + 50) chk("R4 relock", sync, 1);
    end
    chk("R11 flag held", los, 1);
    lat = acc_bit;
    step(0, 1, 1);
    chk("R8 bits total", bit_cnt, lat);
    chk("R5 locked errs", err_cnt, 12);
    chk("R11 flag cleared", los, 0);
    lat = acc_bit;
    step(0, 1, 1);
    chk("R9 cleared errs", err_cnt, 0);
    chk("R9 one clock", bit_cnt, lat);
  endtask

  initial begin
    run_poly(32'h0000_0014, 5);
    run_poly(32'h0000_0060, 7);
    run_poly(32'h0000_0110, 9);
    run_poly(32'h0004_0400, 20);
    // saturation
    do_reset(32'h0000_0060, 7);
    for (int k = 0; k < 1100; k++) step(0, 1, 0);
    step(0, 1, 1);
    chk("R10 saturate", bit_cnt, SAT);
    step(0, 1, 0);
    step(0, 1, 0);
    step(0, 1, 1);
    chk("R9 R10 restart", bit_cnt, 3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #4_000_000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule